// File: doc/BRIEF.md
# Bipolar Return-to-Zero Avionics Word Transmitter

This block turns a host-supplied serial bit stream into the three-level return-to-zero symbols of a 100 kbit/s avionics data bus. The block runs from a 1 MHz reference clock. The host presents one bit per accepted cycle, together with a line-enable flag. The pair goes into a sixteen-slot queue. A divide-by-ten phase counter paces the queue's drain at one slot per 10 µs. Each slot with the enable flag set becomes one symbol. The symbol drives the complementary A and B lines to opposite levels for the first half of the bit period and to null for the second half.

Slots with the enable flag clear still take up one bit period each, but both lines stay null during it. The host packs a 32-bit word as four bytes, bit 0 of byte 1 first. It then appends a fifth byte with the enable flag clear, which guarantees an idle gap between words. Label ordering and parity are the host's concern: the block sends bits in the order it receives them.

A ready flag tells the host when the queue and the line are both idle. A sticky flag records any write that was refused because the queue was full.

Top module: `arinc_rz_tx`

## Requirements
- R1: Each enabled slot lasts exactly 10 reference cycles. Its level is driven for the first 5 cycles and null for the last 5. Back-to-back symbols start 10 cycles apart.
- R2: Line codes are 2'b01 for high, 2'b00 for null and 2'b10 for low. A one drives A high and B low, a zero drives A low and B high, and A and B are always null together.
- R3: A write accepted at clock edge k while the block is idle is seen on the lines from edge k+1.
- R4: Slots leave in the order they were written. For a word sent byte 1 first, each byte least significant bit first, word bit 0 goes out first.
- R5: A slot written with the enable flag low uses one 10-cycle bit period with both lines null. A following enabled slot is therefore delayed by that period.
- R6: tx_ready falls at the edge that accepts a write. It stays low while the queue holds a slot or a symbol is in progress. For a lone bit written at edge k, it rises again at edge k+11.
- R7: The queue holds 16 slots. A write that arrives while it is full is dropped and does not appear in the transmitted stream.
- R8: A dropped write sets overflow at the same edge. The flag stays set until ovf_clr is asserted for one cycle, which clears it at that edge.
- R9: After reset, tx_ready is 1, both lines are null and overflow is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 1 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_valid | input | 1 | One serial bit is presented this cycle |
| ser_data | input | 1 | Serial data bit |
| ser_en | input | 1 | Line-enable flag stored with the bit |
| ovf_clr | input | 1 | Write-one pulse that clears overflow |
| line_a | output | 2 | A-line drive code (01 high, 00 null, 10 low) |
| line_b | output | 2 | B-line drive code, complement of A |
| tx_ready | output | 1 | Queue empty and no symbol in progress |
| overflow | output | 1 | Sticky flag: a write was dropped while full |

## Verification
The hardest condition to reach is a full queue. The queue starts draining one cycle after its first write, so paced writes never fill it. The stimulus therefore sends an unbroken burst of twenty writes, one per cycle. The queue reaches 16 slots at the eighteenth write, after two slots have already left. The last two writes are refused. The test then confirms that overflow rose at exactly the nineteenth write and that precisely the first eighteen bits, in order, appeared on the line.

// File: rtl/arinc_tx_pkg.sv
package arinc_tx_pkg;

  typedef enum logic [1:0] {
    LVL_NULL = 2'b00,
    LVL_HIGH = 2'b01,
    LVL_LOW  = 2'b10
  } lvl_t;

  typedef struct packed {
    logic en;
    logic data;
  } slot_t;

  // Level on the A line for a slot during one half of its bit period.
  function automatic lvl_t a_level(slot_t s, logic drive_half);
    if (!drive_half || !s.en) return LVL_NULL;
    return s.data ? LVL_HIGH : LVL_LOW;
  endfunction

  // B line is the opposite pole of A; null stays null.
  function automatic lvl_t mirror(lvl_t l);
    case (l)
      LVL_HIGH: return LVL_LOW;
      LVL_LOW:  return LVL_HIGH;
      default:  return LVL_NULL;
    endcase
  endfunction

endpackage

// File: rtl/arinc_slot_fifo.sv
module arinc_slot_fifo
  import arinc_tx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  slot_t                      wr_slot,
  input  logic                       pop,
  output slot_t                      rd_slot,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  slot_t          mem [DEPTH];
  logic [AW-1:0]  wp, rp;
  logic [CW-1:0]  cnt;
  logic           push_ok, pop_ok;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign rd_slot = mem[rp];
  assign count   = cnt;

  function automatic logic [AW-1:0] step(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= wr_slot;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_ok) wp <= step(wp);
      if (pop_ok)  rp <= step(rp);
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/arinc_rz_symbol.sv
module arinc_rz_symbol
  import arinc_tx_pkg::*;
#(
  parameter int DIV = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   q_empty,
  input  slot_t                  q_head,
  output logic                   pop,
  output logic                   busy,
  output logic [$clog2(DIV)-1:0] phase,
  output logic                   tick,
  output lvl_t                   a_lvl,
  output lvl_t                   b_lvl
);
  localparam int PW   = $clog2(DIV);
  localparam int HALF = DIV / 2;

  logic [PW-1:0] ph;
  slot_t         cur;
  logic          act;
  logic          drive_half;

  // Last reference cycle of the current bit period.
  assign tick  = act && (ph == PW'(DIV - 1));
  assign pop   = !q_empty && (!act || tick);
  assign busy  = act;
  assign phase = ph;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act <= 1'b0;
      ph  <= '0;
      cur <= '0;
    end else if (pop) begin
      act <= 1'b1;
      ph  <= '0;
      cur <= q_head;
    end else if (tick) begin
      act <= 1'b0;
      ph  <= '0;
    end else if (act) begin
      ph  <= ph + PW'(1);
    end
  end

  assign drive_half = act && (ph < PW'(HALF));
  assign a_lvl      = a_level(cur, drive_half);
  assign b_lvl      = mirror(a_lvl);
endmodule

// File: rtl/arinc_rz_tx.sv
module arinc_rz_tx
  import arinc_tx_pkg::*;
#(
  parameter int REF_DIV    = 10,
  parameter int FIFO_DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_valid,
  input  logic       ser_data,
  input  logic       ser_en,
  input  logic       ovf_clr,
  output logic [1:0] line_a,
  output logic [1:0] line_b,
  output logic       tx_ready,
  output logic       overflow
);
  localparam int CW = $clog2(FIFO_DEPTH + 1);
  localparam int PW = $clog2(REF_DIV);

  // Named internal events for the checker.
  slot_t         head_slot;
  logic [CW-1:0] fifo_count;
  logic          fifo_full, fifo_empty;
  logic          pop_evt, drop_evt;
  logic          sym_busy, sym_tick;
  logic [PW-1:0] sym_phase;
  lvl_t          a_lvl, b_lvl;
  logic          ovf_q;

  assign drop_evt = ser_valid && fifo_full;

  arinc_slot_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (ser_valid),
    .wr_slot ('{en: ser_en, data: ser_data}),
    .pop     (pop_evt),
    .rd_slot (head_slot),
    .count   (fifo_count),
    .full    (fifo_full),
    .empty   (fifo_empty)
  );

  arinc_rz_symbol #(.DIV(REF_DIV)) u_sym (
    .clk     (clk),
    .rst_n   (rst_n),
    .q_empty (fifo_empty),
    .q_head  (head_slot),
    .pop     (pop_evt),
    .busy    (sym_busy),
    .phase   (sym_phase),
    .tick    (sym_tick),
    .a_lvl   (a_lvl),
    .b_lvl   (b_lvl)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        ovf_q <= 1'b0;
    else if (drop_evt) ovf_q <= 1'b1;
    else if (ovf_clr)  ovf_q <= 1'b0;
  end

  assign line_a   = a_lvl;
  assign line_b   = b_lvl;
  assign overflow = ovf_q;
  assign tx_ready = fifo_empty && !sym_busy;

  logic unused_tick;
  assign unused_tick = sym_tick;
endmodule

// File: rtl/arinc_rz_tx_chk.sv
module arinc_rz_tx_chk #(
  parameter int REF_DIV    = 10,
  parameter int FIFO_DEPTH = 16
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [1:0]                     line_a,
  input logic [1:0]                     line_b,
  input logic                           tx_ready,
  input logic                           overflow,
  input logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_count,
  input logic                           sym_busy,
  input logic [$clog2(REF_DIV)-1:0]     sym_phase,
  input logic                           drop_evt
);
  localparam int CW   = $clog2(FIFO_DEPTH + 1);
  localparam int PW   = $clog2(REF_DIV);
  localparam int HALF = REF_DIV / 2;

  AST_LINE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    ((line_a == 2'b00) == (line_b == 2'b00)) && (line_a != 2'b11) &&
    ((line_a == 2'b00) || (line_a != line_b)));                          // R2

  AST_NULL_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_busy && (sym_phase >= PW'(HALF))) |-> (line_a == 2'b00));        // R1

  AST_IDLE_NULL: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_busy |-> (line_a == 2'b00 && line_b == 2'b00));                  // R1

  AST_READY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((fifo_count != '0) || sym_busy) |-> !tx_ready);                      // R6

  AST_COUNT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CW'(FIFO_DEPTH));                                       // R7

  AST_NO_OVERFLOW_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> overflow);                                               // R8
endmodule

bind arinc_rz_tx arinc_rz_tx_chk #(
  .REF_DIV   (REF_DIV),
  .FIFO_DEPTH(FIFO_DEPTH)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .line_a    (line_a),
  .line_b    (line_b),
  .tx_ready  (tx_ready),
  .overflow  (overflow),
  .fifo_count(fifo_count),
  .sym_busy  (sym_busy),
  .sym_phase (sym_phase),
  .drop_evt  (drop_evt)
);

// File: tb/arinc_rz_tx_test.sv
module arinc_rz_tx_test;
  localparam int CLK_NS = 1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_valid = 1'b0, ser_data = 1'b0, ser_en = 1'b0, ovf_clr = 1'b0;
  wire [1:0] line_a, line_b;
  wire tx_ready, overflow;

  always #(CLK_NS/2) clk = ~clk;

  arinc_rz_tx uut (
    .clk(clk), .rst_n(rst_n), .ser_valid(ser_valid), .ser_data(ser_data),
    .ser_en(ser_en), .ovf_clr(ovf_clr), .line_a(line_a), .line_b(line_b),
    .tx_ready(tx_ready), .overflow(overflow)
  );

  int nchk = 0, nfail = 0, cyc = 0, run = 0, nsym = 0;
  logic       sym_bit [64];
  int         sym_t   [64];
  logic [1:0] prev_a = 2'b00;

  task automatic check(string req, int act, int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc++;

  // Symbol monitor: logs each symbol start, checks pole pairing and width.
  always @(negedge clk) begin
    if (rst_n) begin
      if (line_a != 2'b00) begin
        if (prev_a == 2'b00) begin
          check("R2 B opposite of A", int'(line_b),
                (line_a == 2'b01) ? 2 : 1);
          if (nsym < 64) begin
            sym_bit[nsym] = (line_a == 2'b01);
            sym_t[nsym]   = cyc;
          end
          nsym++;
          run = 0;
        end
        run++;
      end else if (prev_a != 2'b00) begin
        check("R1 driven half width", run, 5);
      end
      prev_a = line_a;
    end
  end

  task automatic wait_idle();
    do @(negedge clk); while (!(tx_ready && line_a == 2'b00));
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R9 ready after reset", int'(tx_ready), 1);
    check("R9 line_a null", int'(line_a), 0);
    check("R9 line_b null", int'(line_b), 0);
    check("R9 overflow clear", int'(overflow), 0);
  endtask

  task automatic t_single(logic b);
    nsym = 0;
    @(negedge clk); ser_valid = 1; ser_data = b; ser_en = 1;
    @(negedge clk); ser_valid = 0;
    check("R6 ready falls on write", int'(tx_ready), 0);
    check("R3 nothing before next edge", int'(line_a), 0);
    for (int n = 1; n <= 11; n++) begin
      @(negedge clk);
      if (n <= 5) begin
        check("R3 R2 A level", int'(line_a), b ? 1 : 2);
        check("R2 B level", int'(line_b), b ? 2 : 1);
      end else if (n <= 10) begin
        check("R1 null half", int'(line_a), 0);
        check("R6 ready low in null half", int'(tx_ready), 0);
      end else begin
        check("R6 ready at k+11", int'(tx_ready), 1);
      end
    end
    check("R1 one symbol", nsym, 1);
  endtask

  task automatic t_word(logic [31:0] w);
    nsym = 0;
    for (int i = 0; i <= 40; i++) begin
      @(negedge clk);
      ser_valid = 1;
      ser_en    = (i < 32) || (i == 40);
      ser_data  = (i < 32) ? w[i] : 1'b1;
      @(negedge clk); ser_valid = 0;
      repeat (6) @(negedge clk);
    end
    wait_idle();
    check("R4 symbol count", nsym, 33);
    for (int i = 0; i < 32; i++) check("R4 bit order", int'(sym_bit[i]), int'(w[i]));
    for (int i = 0; i < 31; i++) check("R1 symbol spacing", sym_t[i+1] - sym_t[i], 10);
    check("R5 gap after eight null slots", sym_t[32] - sym_t[31], 90);
    check("R5 next word bit", int'(sym_bit[32]), 1);
  endtask

  task automatic t_null_only();
    nsym = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); ser_valid = 1; ser_data = 1; ser_en = 0;
    end
    @(negedge clk); ser_valid = 0;
    for (int n = 1; n <= 29; n++) begin
      @(negedge clk);
      if (n <= 28) begin
        check("R5 line null", int'(line_a), 0);
        check("R6 ready low over null slots", int'(tx_ready), 0);
      end else begin
        check("R5 R6 ready after three slots", int'(tx_ready), 1);
      end
    end
    check("R5 no symbols", nsym, 0);
  endtask

  task automatic t_overflow(logic [19:0] pat);
    nsym = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (i > 0) check("R8 overflow at full", int'(overflow), (i - 1 >= 18) ? 1 : 0);
      ser_valid = 1; ser_en = 1; ser_data = pat[i];
    end
    @(negedge clk); ser_valid = 0;
    check("R8 overflow set", int'(overflow), 1);
    repeat (50) @(negedge clk);
    check("R8 overflow sticky", int'(overflow), 1);
    wait_idle();
    check("R7 accepted count", nsym, 18);
    for (int i = 0; i < 18; i++) check("R7 accepted bits", int'(sym_bit[i]), int'(pat[i]));
    @(negedge clk); ovf_clr = 1;
    @(negedge clk); ovf_clr = 0;
    check("R8 cleared by pulse", int'(overflow), 0);
  endtask

  initial begin
    #(CLK_NS * 200000);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_single(1'b1);
    t_single(1'b0);
    wait_idle();
    t_word(32'hA5C3_0F96);
    t_null_only();
    wait_idle();
    t_overflow(20'h6B2D9);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule